// File: doc/BRIEF.md
# Two-Partition Cache with Hidden Cross-Partition Copy

This block is a small set-associative read cache shared by two processes that never share ways. A one-bit process identifier on each request picks the partition: value 1 marks the protected (victim) process and gives it the upper group of ways, value 0 marks the untrusted (attacker) process and gives it the lower group. A request can look up, fill and flush only the ways of its own group. When a read misses in its own group but the same line is resident in the other group, the line is copied across without a memory access. The copy still takes exactly as long as a memory miss, so the requester cannot learn whether the other process holds the line.

As a timing-noise countermeasure, an internal 16-bit LFSR can make the block drop one valid line of the victim group in the set just accessed, after each response is taken. The attacker group is never touched by this noise. Requests and responses use valid/ready handshakes. Only one request is in flight at a time: `req_ready` is high only while the block is idle with no response pending, and a response holds `rsp_valid`, `rsp_data` and `rsp_hit` stable until `rsp_ready` takes it. The memory port is fixed-latency. The block holds `mem_req` and `mem_addr` for `MISS_LAT-1` cycles and samples `mem_rdata` in the last of them.

Top module: `spc_cache`

## Requirements
- R1: A request with `req_pid`=1 can hit only lines held in the victim ways, and a request with `req_pid`=0 can hit only lines held in the attacker ways. A line resident only in the other group is never reported as a hit.
- R2: A read that hits in its own group raises `rsp_valid` one cycle after the accepting handshake, with `rsp_hit`=1, the line data, and no `mem_req`.
- R3: A read that misses in both groups drives `mem_req` with `mem_addr` equal to the request address for `MISS_LAT-1` cycles. It returns the `mem_rdata` sampled in the last of those cycles, with `rsp_hit`=0, `MISS_LAT` cycles after acceptance, and installs the line in the requester's group.
- R4: A read that misses in its own group while the line sits in the other group copies the line across. It never raises `mem_req` and answers with `rsp_hit`=0 after exactly `MISS_LAT` cycles. Afterwards the line hits in both groups.
- R5: `req_op`=1 (flush) invalidates the addressed line only in the requester's group and answers one cycle later. `rsp_hit` is 1 if the line was present there and 0 otherwise. A copy of the line in the other group stays valid.
- R6: A fill goes to the lowest-index invalid way of the requester's group in that set; if none is invalid, it replaces the least recently used way of that group. Hits and fills count as uses.
- R7: While `noise_en`=1 and (LFSR[MASK_W-1:0] & `noise_mask`) is zero at a response handshake, one valid victim way of the accessed set is invalidated. If the LFSR-chosen way is invalid, the lowest-index valid way is dropped instead. Attacker ways are never affected.
- R8: `req_ready` is high only while the block is idle with no response pending. A response stays valid and unchanged while `rsp_ready` is low.
- R9: The set index is `req_addr[SET_W-1:0]` and the tag is the remaining upper bits, so lines that differ only in their low bits occupy different sets.
- R10: After reset all lines are invalid, `req_ready`=1, `rsp_valid`=0 and `mem_req`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can accept a request |
| req_pid | input | 1 | 1 = victim process, 0 = attacker process |
| req_op | input | 1 | 0 = read, 1 = flush |
| req_addr | input | ADDR_W | Line address |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | DATA_W | Line data (zero for a flush) |
| rsp_hit | output | 1 | Hit in own group (read) or line was present (flush) |
| mem_req | output | 1 | Memory read in progress |
| mem_addr | output | ADDR_W | Memory line address |
| mem_rdata | input | DATA_W | Memory data, sampled in the last request cycle |
| noise_en | input | 1 | Enables random victim invalidation |
| noise_mask | input | MASK_W | Selects LFSR bits that must be zero to trigger |

## Verification
The embedded assertions check the following on every cycle:
- Responses are held under back-pressure, and no request is accepted while a response is pending.
- A hit answers on the next cycle.
- The end of a memory request coincides with the response.
- A cross-partition copy never raises `mem_req`.
- The attacker ways lose lines only through their own flush.
- No tag appears twice in one set of one group.

Some properties only the bench's scenarios can show, because they depend on the history of earlier requests: the exact miss and copy latency as seen at the ports, the data returned, LRU victim choice, the set mapping, and the victim line that noise actually removes.

// File: rtl/spc_pkg.sv
package spc_pkg;
  typedef enum logic {
    OP_READ  = 1'b0,
    OP_FLUSH = 1'b1
  } spc_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_MISS,
    ST_RESP
  } spc_state_e;

  localparam logic PID_ATTACK = 1'b0;
  localparam logic PID_VICTIM = 1'b1;
endpackage

// File: rtl/spc_lfsr.sv
module spc_lfsr #(
  parameter int          W    = 16,
  parameter logic [15:0] TAPS = 16'hB400,
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] value
);
  logic [W-1:0] q;

  always_ff @(posedge clk) begin
    if (!rst_n) q <= SEED[W-1:0];
    else        q <= {1'b0, q[W-1:1]} ^ (q[0] ? TAPS[W-1:0] : '0);
  end

  assign value = q;

  // R7
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q != '0);
endmodule

// File: rtl/spc_bank.sv
module spc_bank #(
  parameter int NSETS  = 4,
  parameter int WPP    = 2,
  parameter int TAG_W  = 10,
  parameter int DATA_W = 32,
  localparam int SET_W = $clog2(NSETS),
  localparam int WAY_W = $clog2(WPP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SET_W-1:0]  lk_set,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic              lk_hit,
  output logic [WAY_W-1:0]  lk_way,
  output logic [DATA_W-1:0] lk_data,
  output logic [WAY_W-1:0]  repl_way,
  output logic [WPP-1:0]    valid_vec,
  input  logic [WAY_W-1:0]  wr_way,
  input  logic              fill_en,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              touch_en,
  input  logic              inval_en
);
  logic              valid_q [NSETS][WPP];
  logic [TAG_W-1:0]  tag_q   [NSETS][WPP];
  logic [DATA_W-1:0] data_q  [NSETS][WPP];
  logic [WAY_W-1:0]  age_q   [NSETS][WPP];
  logic [WPP-1:0]    match;

  for (genvar w = 0; w < WPP; w++) begin : g_cmp
    assign match[w]     = valid_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
    assign valid_vec[w] = valid_q[lk_set][w];
  end

  assign lk_hit  = |match;
  assign lk_data = data_q[lk_set][lk_way];

  always_comb begin
    lk_way = '0;
    for (int w = 0; w < WPP; w++)
      if (match[w]) lk_way = WAY_W'(w);
  end

  // Lowest invalid way first, otherwise the oldest way.
  always_comb begin
    repl_way = '0;
    for (int w = 0; w < WPP; w++)
      if (age_q[lk_set][w] == WAY_W'(WPP - 1)) repl_way = WAY_W'(w);
    for (int w = WPP - 1; w >= 0; w--)
      if (!valid_q[lk_set][w]) repl_way = WAY_W'(w);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NSETS; s++)
        for (int w = 0; w < WPP; w++) begin
          valid_q[s][w] <= 1'b0;
          age_q[s][w]   <= WAY_W'(w);
        end
    end else begin
      if (fill_en) valid_q[lk_set][wr_way] <= 1'b1;
      if (inval_en) valid_q[lk_set][wr_way] <= 1'b0;
      if (fill_en || touch_en) begin
        for (int w = 0; w < WPP; w++) begin
          if (WAY_W'(w) == wr_way)
            age_q[lk_set][w] <= '0;
          else if (age_q[lk_set][w] < age_q[lk_set][wr_way])
            age_q[lk_set][w] <= age_q[lk_set][w] + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[lk_set][wr_way]  <= lk_tag;
      data_q[lk_set][wr_way] <= fill_data;
    end
  end

  // R6
  one_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fill_en, touch_en, inval_en}));

  // R3
  no_dup_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));
endmodule

// File: rtl/spc_cache.sv
module spc_cache
  import spc_pkg::*;
#(
  parameter int NSETS    = 4,
  parameter int WPP      = 2,
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int MISS_LAT = 8,
  parameter int MASK_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_pid,
  input  logic              req_op,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_hit,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              noise_en,
  input  logic [MASK_W-1:0] noise_mask
);
  localparam int SET_W = $clog2(NSETS);
  localparam int TAG_W = ADDR_W - SET_W;
  localparam int WAY_W = $clog2(WPP);
  localparam int CNT_W = $clog2(MISS_LAT);
  localparam int LFSR_W = 16;

  spc_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              pid_q;
  logic [ADDR_W-1:0] addr_q;
  logic              copy_q;
  logic [DATA_W-1:0] copy_data_q;
  logic [DATA_W-1:0] rsp_data_q;
  logic              rsp_hit_q;

  logic              cur_pid;
  logic [ADDR_W-1:0] cur_addr;
  logic [SET_W-1:0]  cur_set;
  logic [TAG_W-1:0]  cur_tag;
  logic              accept, own_hit, oth_hit, noise_fire;
  logic [LFSR_W-1:0] lfsr;
  logic [WAY_W-1:0]  noise_way;
  logic [DATA_W-1:0] fill_data;

  logic [1:0]        b_hit, b_fill, b_touch, b_inval;
  logic [WAY_W-1:0]  b_way  [2];
  logic [WAY_W-1:0]  b_repl [2];
  logic [WAY_W-1:0]  b_wway [2];
  logic [DATA_W-1:0] b_data [2];
  logic [WPP-1:0]    b_vld  [2];

  spc_lfsr #(.W(LFSR_W)) u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .value (lfsr)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign cur_pid   = (state_q == ST_IDLE) ? req_pid : pid_q;
  assign cur_addr  = (state_q == ST_IDLE) ? req_addr : addr_q;
  assign cur_set   = cur_addr[SET_W-1:0];
  assign cur_tag   = cur_addr[ADDR_W-1:SET_W];
  assign own_hit   = b_hit[cur_pid];
  assign oth_hit   = b_hit[~cur_pid];
  assign fill_data = copy_q ? copy_data_q : mem_rdata;

  // index 0: attacker ways, index 1: victim ways
  for (genvar b = 0; b < 2; b++) begin : g_bank
    spc_bank #(
      .NSETS  (NSETS),
      .WPP    (WPP),
      .TAG_W  (TAG_W),
      .DATA_W (DATA_W)
    ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .lk_set    (cur_set),
      .lk_tag    (cur_tag),
      .lk_hit    (b_hit[b]),
      .lk_way    (b_way[b]),
      .lk_data   (b_data[b]),
      .repl_way  (b_repl[b]),
      .valid_vec (b_vld[b]),
      .wr_way    (b_wway[b]),
      .fill_en   (b_fill[b]),
      .fill_data (fill_data),
      .touch_en  (b_touch[b]),
      .inval_en  (b_inval[b])
    );
  end

  assign noise_fire = noise_en && ((lfsr[MASK_W-1:0] & noise_mask) == '0);

  always_comb begin
    noise_way = lfsr[MASK_W +: WAY_W];
    if (!b_vld[PID_VICTIM][noise_way]) begin
      noise_way = '0;
      for (int w = WPP - 1; w >= 0; w--)
        if (b_vld[PID_VICTIM][w]) noise_way = WAY_W'(w);
    end
  end

  always_comb begin
    for (int b = 0; b < 2; b++) begin
      b_fill[b]  = 1'b0;
      b_touch[b] = 1'b0;
      b_inval[b] = 1'b0;
      b_wway[b]  = b_way[b];
      if (accept && (cur_pid == 1'(b)) && own_hit) begin
        if (req_op == OP_READ) b_touch[b] = 1'b1;
        else                   b_inval[b] = 1'b1;
      end
      if ((state_q == ST_MISS) && (cnt_q == '0) && (pid_q == 1'(b))) begin
        b_fill[b] = 1'b1;
        b_wway[b] = b_repl[b];
      end
      if ((1'(b) == PID_VICTIM) && (state_q == ST_RESP) && rsp_ready &&
          noise_fire && (|b_vld[b])) begin
        b_inval[b] = 1'b1;
        b_wway[b]  = noise_way;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      pid_q       <= 1'b0;
      addr_q      <= '0;
      copy_q      <= 1'b0;
      copy_data_q <= '0;
      rsp_data_q  <= '0;
      rsp_hit_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          pid_q  <= req_pid;
          addr_q <= req_addr;
          if (req_op == OP_FLUSH) begin
            rsp_hit_q  <= own_hit;
            rsp_data_q <= '0;
            state_q    <= ST_RESP;
          end else if (own_hit) begin
            rsp_hit_q  <= 1'b1;
            rsp_data_q <= b_data[cur_pid];
            state_q    <= ST_RESP;
          end else begin
            copy_q      <= oth_hit;
            copy_data_q <= b_data[~cur_pid];
            cnt_q       <= CNT_W'(MISS_LAT - 2);
            state_q     <= ST_MISS;
          end
        end
        ST_MISS: begin
          if (cnt_q == '0) begin
            rsp_hit_q  <= 1'b0;
            rsp_data_q <= fill_data;
            state_q    <= ST_RESP;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_RESP: if (rsp_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rsp_valid = (state_q == ST_RESP);
  assign rsp_data  = rsp_data_q;
  assign rsp_hit   = rsp_hit_q;
  assign mem_req   = (state_q == ST_MISS) && !copy_q;
  assign mem_addr  = addr_q;

  // R8
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_hit));

  // R8
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  // R2
  hit_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (req_op == OP_READ) && own_hit |=> rsp_valid && rsp_hit);

  // R3
  mem_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_req) |-> rsp_valid);

  // R3
  mem_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req || $stable(mem_addr));

  // R4
  copy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (req_op == OP_READ) && !own_hit && oth_hit |=> !mem_req);

  // R7
  attacker_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    b_inval[PID_ATTACK] |-> accept && (req_op == OP_FLUSH));
endmodule

// File: tb/spc_cache_test.sv
module spc_cache_test;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int MISS_LAT = 8;
  localparam int MASK_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_pid = 1'b0, req_op = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic req_ready, rsp_valid, rsp_hit, mem_req;
  logic rsp_ready = 1'b1;
  logic [DATA_W-1:0] rsp_data, mem_rdata;
  logic [ADDR_W-1:0] mem_addr;
  logic noise_en = 1'b0;
  logic [MASK_W-1:0] noise_mask = '1;

  int checks = 0, errors = 0, cyc = 0;
  logic [31:0] q_data[$];
  logic        q_hit[$];
  bit          q_chkd[$];
  int          q_lat[$], q_mem[$], q_acc[$];
  string       q_req[$];
  int memcnt = 0, first = 0;
  bit seen = 0, addr_bad = 0;
  logic [ADDR_W-1:0] drv_addr = '0;

  spc_cache uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_pid(req_pid),
    .req_op(req_op), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_hit(rsp_hit),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .noise_en(noise_en), .noise_mask(noise_mask)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] mdata(input logic [ADDR_W-1:0] a);
    return 32'h9E37_0000 ^ {20'h0, a} ^ ({20'h0, a} << 16);
  endfunction

  assign mem_rdata = mdata(mem_addr);

  task automatic check(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard when a response is taken.
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req) begin
        memcnt++;
        if (mem_addr != drv_addr) addr_bad = 1;
      end
      if (rsp_valid && !seen) begin
        seen = 1;
        first = cyc;
      end
      if (rsp_valid && rsp_ready) begin
        if (q_lat.size() == 0) begin
          check(0, "R8 unexpected response", 1, 0);
        end else begin
          automatic string r = q_req.pop_front();
          automatic logic [31:0] ed = q_data.pop_front();
          automatic logic eh = q_hit.pop_front();
          automatic bit cd = q_chkd.pop_front();
          automatic int el = q_lat.pop_front();
          automatic int em = q_mem.pop_front();
          automatic int ea = q_acc.pop_front();
          check(rsp_hit == eh, {r, " hit"}, rsp_hit, eh);
          if (cd) check(rsp_data == ed, {r, " data"}, rsp_data, ed);
          check(first - ea == el, {r, " latency"}, first - ea, el);
          check(memcnt == em, {r, " mem cycles"}, memcnt, em);
          check(!addr_bad, {r, " R3 mem_addr"}, addr_bad, 0);
        end
        memcnt = 0;
        seen = 0;
        addr_bad = 0;
      end
    end
  end

  // Driver: issues one request, records expectations, waits for completion.
  task automatic do_req(input logic pid, input logic op, input logic [ADDR_W-1:0] a,
                        input logic eh, input int el, input int em, input string r,
                        input bit hold = 0);
    @(negedge clk);
    req_valid = 1; req_pid = pid; req_op = op; req_addr = a;
    while (!req_ready) @(negedge clk);
    drv_addr = a;
    q_acc.push_back(cyc);
    q_data.push_back(mdata(a));
    q_hit.push_back(eh);
    q_chkd.push_back(op == 1'b0);
    q_lat.push_back(el);
    q_mem.push_back(em);
    q_req.push_back(r);
    @(negedge clk);
    req_valid = 0;
    if (!hold) while (q_lat.size() != 0) @(negedge clk);
  endtask

  localparam logic V = 1'b1, A = 1'b0, RD = 1'b0, FL = 1'b1;
  localparam int ML = MISS_LAT, MC = MISS_LAT - 1;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(req_ready == 1, "R10 req_ready", req_ready, 1);
    check(rsp_valid == 0, "R10 rsp_valid", rsp_valid, 0);
    check(mem_req == 0, "R10 mem_req", mem_req, 0);

    do_req(V, RD, 12'h010, 0, ML, MC, "R3 victim cold miss");
    do_req(V, RD, 12'h010, 1, 1, 0, "R2 victim hit");
    do_req(A, RD, 12'h010, 0, ML, 0, "R4 R1 attacker copy");
    do_req(A, RD, 12'h010, 1, 1, 0, "R4 attacker hit after copy");
    do_req(A, FL, 12'h010, 1, 1, 0, "R5 attacker flush present");
    do_req(V, RD, 12'h010, 1, 1, 0, "R5 victim copy survives");
    do_req(A, RD, 12'h010, 0, ML, 0, "R5 R4 attacker refetch by copy");
    do_req(A, FL, 12'h020, 0, 1, 0, "R5 flush absent");

    do_req(A, RD, 12'h080, 0, ML, MC, "R9 set0 miss");
    do_req(A, RD, 12'h081, 0, ML, MC, "R9 set1 miss");
    do_req(A, RD, 12'h082, 0, ML, MC, "R9 set2 miss");
    do_req(A, RD, 12'h080, 1, 1, 0, "R9 set0 hit");
    do_req(A, RD, 12'h081, 1, 1, 0, "R9 set1 hit");
    do_req(A, RD, 12'h082, 1, 1, 0, "R9 set2 hit");

    rsp_ready = 0;
    do_req(A, RD, 12'h080, 1, 1, 0, "R8 held hit", 1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(rsp_valid == 1, "R8 held valid", rsp_valid, 1);
      check(req_ready == 0, "R8 ready low", req_ready, 0);
      check(rsp_data == mdata(12'h080), "R8 held data", rsp_data, mdata(12'h080));
    end
    rsp_ready = 1;
    while (q_lat.size() != 0) @(negedge clk);

    do_req(V, RD, 12'h101, 0, ML, MC, "R6 fill way0");
    do_req(V, RD, 12'h201, 0, ML, MC, "R6 fill way1");
    do_req(V, RD, 12'h101, 1, 1, 0, "R6 touch");
    do_req(V, RD, 12'h301, 0, ML, MC, "R6 evict lru");
    do_req(V, RD, 12'h101, 1, 1, 0, "R6 mru kept");
    do_req(V, RD, 12'h201, 0, ML, MC, "R6 evicted line misses");
    do_req(V, RD, 12'h101, 1, 1, 0, "R6 mru still kept");

    noise_mask = '0;
    noise_en = 1;
    do_req(A, RD, 12'h0C3, 0, ML, MC, "R7 attacker fill");
    do_req(A, RD, 12'h0C3, 1, 1, 0, "R7 attacker untouched 1");
    do_req(A, RD, 12'h0C3, 1, 1, 0, "R7 attacker untouched 2");
    do_req(V, RD, 12'h0D3, 0, ML, MC, "R7 victim fill");
    do_req(V, RD, 12'h0D3, 0, ML, MC, "R7 victim dropped");
    noise_en = 0;
    do_req(V, RD, 12'h0D3, 0, ML, MC, "R7 victim dropped again");
    do_req(V, RD, 12'h0D3, 1, 1, 0, "R7 noise off keeps line");
    do_req(A, RD, 12'h0C3, 1, 1, 0, "R7 attacker still resident");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule